// File: doc/BRIEF.md
# Pointer-Table Scan Line Address Generator

This block walks a monochrome bitmap frame one scan line at a time. It does not assume that lines follow each other in memory. For every displayed line it first reads a two-byte pointer from a table in RAM, then fetches that line's pixel bytes at a stride of eight addresses, and turns each byte into single-bit pixels. The table lies in a 512-byte section that software can move around. The entry used for the top line is programmable, and later lines take entries in order, wrapping inside the section, so rolling or scrolling the picture needs only a one-byte register change. Sync generation and the RAM itself sit outside the block.

A frame starts on a `frame_start` pulse. On that pulse the block latches the table base, the top entry and the frame-rate option. Memory reads go through a request channel (valid/ready) plus a response strobe, with exactly one read in flight at a time. A request, once raised, keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen. The response can come any number of cycles later (at least one) and is taken on `mem_rsp_valid` without back-pressure. Pixels leave on a valid/ready stream. A pixel that is offered stays offered, with its line and frame markers unchanged, until it is accepted. A stalled pixel sink stops further pixel fetches after one byte of buffering. Video control is a one-cycle write port: bit 7 selects reverse video, bit 6 enables video, and bits 5 to 0 are ignored.

Top module: `scanaddr_gen`

## Requirements
- R1: The pointer entry for display line L is read at address {tbl_base[7:5], tbl_base[4:0], (top_entry+L) mod 256, b}. The low byte (b=0) is read before the high byte (b=1), and the 8-bit index wraps within the 512-byte section.
- R2: A pointer P = {high,low} names block P[15:13] and line start offset {P[12:3], 0, P[2:0]}. The first pixel byte of the line is read at {P[15:13], offset}.
- R3: Pixel byte k of a line (k = 0 to BYTES-1, default 90) is read at {P[15:13], (offset + 8k) mod 2^14}.
- R4: A frame covers LINES_50 lines (default 256) when rate_60 is 0, and LINES_60 lines (default 200) when rate_60 is 1. After the last line the block issues no further requests until the next accepted frame_start.
- R5: Both pointer reads of a line complete before the first pixel read of that line, and no new request is raised while a read is awaiting its response.
- R6: While mem_req_valid is high and mem_req_ready is low, the request stays valid with an unchanged address.
- R7: Each byte leaves as 8 pixels, bit 7 first. pix_eol marks the last pixel of each line and pix_eof the last pixel of the frame. A stalled pixel keeps valid, eol and eof unchanged.
- R8: With video enabled, pix_data is the stored bit XOR the reverse flag. With video disabled, pix_data is 0 for every pixel.
- R9: After reset, reverse and enable are both off and no request or pixel is offered.
- R10: Bits 5 to 0 of a video control write have no effect on the pixel stream.
- R11: A frame_start pulse while a frame is being fetched is ignored. Changes to tbl_base, top_entry and rate_60 after a frame has started do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that starts a frame when idle |
| tbl_base | input | 8 | Table block (7:5) and section bits A13..A9 (4:0) |
| top_entry | input | 8 | Table entry used for the top line |
| rate_60 | input | 1 | 1 selects the shorter line count |
| vctl_wr | input | 1 | Video control write strobe |
| vctl_data | input | 8 | Bit 7 reverse, bit 6 enable |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 17 | Block (16:14) and offset (13:0) |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 8 | Read data |
| pix_valid | output | 1 | Pixel valid |
| pix_ready | input | 1 | Pixel accepted |
| pix_data | output | 1 | Pixel value |
| pix_eol | output | 1 | Last pixel of a line |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
A wrong line counter or a corrupted pointer register shows up on the memory request port at once. The next pointer read goes to the wrong entry address, or the next pixel read gets the wrong block or offset, within a few cycles of the fault. A fault in the byte buffer or shifter shows only at the pixel port, as a wrong bit or a misplaced line or frame marker. This can lag the fault by up to two bytes of pixels. A stuck sequencer state appears as requests during a response wait, or as a frame that never produces its frame marker.

// File: rtl/scanaddr_pkg.sv
package scanaddr_pkg;
  localparam int BLK_W     = 3;
  localparam int OFS_W     = 14;
  localparam int ADDR_W    = BLK_W + OFS_W;
  localparam int IDX_W     = 8;
  localparam int STRIDE_SH = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLO_REQ,
    ST_PLO_WAIT,
    ST_PHI_REQ,
    ST_PHI_WAIT,
    ST_PIX_REQ,
    ST_PIX_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       eol;
    logic       eof;
  } pix_byte_t;
endpackage

// File: rtl/scanaddr_addr.sv
module scanaddr_addr
  import scanaddr_pkg::*;
#(
  parameter int BYTE_W = 7
) (
  input  logic [7:0]        base,
  input  logic [IDX_W-1:0]  entry_idx,
  input  logic [15:0]       ptr,
  input  logic [BYTE_W-1:0] byte_idx,
  input  logic              sel_ptr,
  input  logic              sel_hi,
  output logic [ADDR_W-1:0] addr
);
  logic [OFS_W-1:0] line_ofs;
  logic [OFS_W-1:0] step;
  logic [OFS_W-1:0] pix_ofs;

  // start offset has bit 3 clear; the pointer carries the other 13 bits
  assign line_ofs = {ptr[12:3], 1'b0, ptr[2:0]};
  assign step     = OFS_W'(byte_idx) << STRIDE_SH;
  assign pix_ofs  = line_ofs + step;

  always_comb begin
    if (sel_ptr) addr = {base, entry_idx, sel_hi};
    else         addr = {ptr[15:13], pix_ofs};
  end
endmodule

// File: rtl/scanaddr_seq.sv
module scanaddr_seq
  import scanaddr_pkg::*;
#(
  parameter int BYTES    = 90,
  parameter int LINES_50 = 256,
  parameter int LINES_60 = 200,
  localparam int BYTE_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int LINE_W  = (LINES_50 > 1) ? $clog2(LINES_50) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [7:0]        tbl_base,
  input  logic [7:0]        top_entry,
  input  logic              rate_60,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  input  logic              buf_free,
  output logic              mem_req_valid,
  output logic              sel_ptr,
  output logic              sel_hi,
  output logic [IDX_W-1:0]  entry_idx,
  output logic [BYTE_W-1:0] byte_idx,
  output logic [7:0]        base_q,
  output logic [15:0]       ptr_q,
  output logic              push,
  output pix_byte_t         push_byte
);
  seq_state_e        st_q, st_d;
  logic [7:0]        top_q;
  logic              rate_q;
  logic [LINE_W-1:0] line_q;
  logic [BYTE_W-1:0] byte_q;
  logic              last_byte, last_line;

  assign last_byte = (byte_q == BYTE_W'(BYTES - 1));
  assign last_line = rate_q ? (line_q == LINE_W'(LINES_60 - 1))
                            : (line_q == LINE_W'(LINES_50 - 1));
  assign entry_idx = top_q + IDX_W'(line_q);
  assign byte_idx  = byte_q;

  assign sel_ptr       = (st_q == ST_PLO_REQ) || (st_q == ST_PHI_REQ);
  assign sel_hi        = (st_q == ST_PHI_REQ);
  assign mem_req_valid = sel_ptr || ((st_q == ST_PIX_REQ) && buf_free);

  assign push           = (st_q == ST_PIX_WAIT) && mem_rsp_valid;
  assign push_byte.data = mem_rsp_data;
  assign push_byte.eol  = last_byte;
  assign push_byte.eof  = last_byte && last_line;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (frame_start) st_d = ST_PLO_REQ;
      ST_PLO_REQ:  if (mem_req_ready) st_d = ST_PLO_WAIT;
      ST_PLO_WAIT: if (mem_rsp_valid) st_d = ST_PHI_REQ;
      ST_PHI_REQ:  if (mem_req_ready) st_d = ST_PHI_WAIT;
      ST_PHI_WAIT: if (mem_rsp_valid) st_d = ST_PIX_REQ;
      ST_PIX_REQ:  if (buf_free && mem_req_ready) st_d = ST_PIX_WAIT;
      ST_PIX_WAIT: begin
        if (mem_rsp_valid) begin
          if (!last_byte)     st_d = ST_PIX_REQ;
          else if (last_line) st_d = ST_IDLE;
          else                st_d = ST_PLO_REQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      top_q  <= '0;
      rate_q <= 1'b0;
      line_q <= '0;
      byte_q <= '0;
      ptr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && frame_start) begin
        base_q <= tbl_base;
        top_q  <= top_entry;
        rate_q <= rate_60;
        line_q <= '0;
      end
      if (st_q == ST_PLO_WAIT && mem_rsp_valid) ptr_q[7:0] <= mem_rsp_data;
      if (st_q == ST_PHI_WAIT && mem_rsp_valid) begin
        ptr_q[15:8] <= mem_rsp_data;
        byte_q      <= '0;
      end
      if (push) begin
        if (!last_byte)      byte_q <= byte_q + 1'b1;
        else if (!last_line) line_q <= line_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanaddr_shift.sv
module scanaddr_shift
  import scanaddr_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  pix_byte_t push_byte,
  input  logic      reverse,
  input  logic      video_en,
  input  logic      pix_ready,
  output logic      buf_free,
  output logic      pix_valid,
  output logic      pix_data,
  output logic      pix_eol,
  output logic      pix_eof
);
  pix_byte_t  hold_q;
  logic       hold_full;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       sh_eol, sh_eof;
  logic       fire, load, cur_bit;
  logic [7:0] sh_next;

  generate
    if (MSB_FIRST) begin : g_msb
      assign cur_bit = sh_q[7];
      assign sh_next = {sh_q[6:0], 1'b0};
    end else begin : g_lsb
      assign cur_bit = sh_q[0];
      assign sh_next = {1'b0, sh_q[7:1]};
    end
  endgenerate

  assign pix_valid = (cnt_q != 4'd0);
  assign fire      = pix_valid && pix_ready;
  assign load      = hold_full && ((cnt_q == 4'd0) || (cnt_q == 4'd1 && fire));
  assign buf_free  = !hold_full;
  assign pix_data  = video_en && (cur_bit ^ reverse);
  assign pix_eol   = (cnt_q == 4'd1) && sh_eol;
  assign pix_eof   = (cnt_q == 4'd1) && sh_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      sh_eol    <= 1'b0;
      sh_eof    <= 1'b0;
    end else begin
      if (load) hold_full <= 1'b0;
      if (push) begin
        hold_q    <= push_byte;
        hold_full <= 1'b1;
      end
      if (load) begin
        sh_q   <= hold_q.data;
        cnt_q  <= 4'd8;
        sh_eol <= hold_q.eol;
        sh_eof <= hold_q.eof;
      end else if (fire) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q - 4'd1;
      end
    end
  end
endmodule

// File: rtl/scanaddr_gen.sv
module scanaddr_gen
  import scanaddr_pkg::*;
#(
  parameter int BYTES    = 90,
  parameter int LINES_50 = 256,
  parameter int LINES_60 = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [7:0]        tbl_base,
  input  logic [7:0]        top_entry,
  input  logic              rate_60,
  input  logic              vctl_wr,
  input  logic [7:0]        vctl_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_data,
  output logic              pix_eol,
  output logic              pix_eof
);
  localparam int BYTE_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic              rev_q, en_q;
  logic              buf_free, push, sel_ptr, sel_hi;
  logic [IDX_W-1:0]  entry_idx;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        base_q;
  logic [15:0]       ptr_q;
  pix_byte_t         push_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (vctl_wr) begin
      rev_q <= vctl_data[7];
      en_q  <= vctl_data[6];
    end
  end

  scanaddr_seq #(
    .BYTES(BYTES), .LINES_50(LINES_50), .LINES_60(LINES_60)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .tbl_base(tbl_base), .top_entry(top_entry), .rate_60(rate_60),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .buf_free(buf_free),
    .mem_req_valid(mem_req_valid), .sel_ptr(sel_ptr), .sel_hi(sel_hi),
    .entry_idx(entry_idx), .byte_idx(byte_idx), .base_q(base_q),
    .ptr_q(ptr_q), .push(push), .push_byte(push_byte)
  );

  scanaddr_addr #(.BYTE_W(BYTE_W)) addr_i (
    .base(base_q), .entry_idx(entry_idx), .ptr(ptr_q), .byte_idx(byte_idx),
    .sel_ptr(sel_ptr), .sel_hi(sel_hi), .addr(mem_req_addr)
  );

  scanaddr_shift #(.MSB_FIRST(1'b1)) shift_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_byte(push_byte),
    .reverse(rev_q), .video_en(en_q), .pix_ready(pix_ready),
    .buf_free(buf_free), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_eol(pix_eol), .pix_eof(pix_eof)
  );
endmodule

// File: rtl/scanaddr_chk.sv
module scanaddr_chk
  import scanaddr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              pix_data,
  input logic              pix_eol,
  input logic              pix_eof,
  input logic              vctl_wr,
  input logic [7:0]        vctl_data
);
  logic outst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid) outst_q <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_valid); // R5

  AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_eol) && $stable(pix_eof))); // R7

  AST_EOF_ENDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_eof) |-> pix_eol); // R7

  AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vctl_wr && !vctl_data[6]) |=> !pix_data); // R8
endmodule

bind scanaddr_gen scanaddr_chk chk_i (.*);

// File: tb/scanaddr_gen_tb_top.sv
module scanaddr_gen_tb_top;
  localparam int BYTES = 4;
  localparam int L50   = 3;
  localparam int L60   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [7:0]  tbl_base = '0;
  logic [7:0]  top_entry = '0;
  logic        rate_60 = 1'b0;
  logic        vctl_wr = 1'b0;
  logic [7:0]  vctl_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [16:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic        pix_data, pix_eol, pix_eof;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [16:0] req_a [0:255];
  int          req_n;
  logic        px_d [0:2047];
  logic        px_l [0:2047];
  logic        px_f [0:2047];
  int          pix_n;
  logic        done;
  logic        pend;
  logic [1:0]  dly;
  logic [16:0] paddr;
  int          outst_err, stall_err;
  logic        rstall_q, pstall_q, pstall_eol;
  logic [16:0] rstall_a;
  logic        cur_rev = 1'b0, cur_en = 1'b0;

  always #4 clk = ~clk;

  scanaddr_gen #(.BYTES(BYTES), .LINES_50(L50), .LINES_60(L60)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tbl_base(tbl_base),
    .top_entry(top_entry), .rate_60(rate_60), .vctl_wr(vctl_wr),
    .vctl_data(vctl_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_eol(pix_eol), .pix_eof(pix_eof)
  );

  function automatic logic [7:0] hb(input logic [16:0] a);
    logic [7:0] t;
    t  = a[7:0] ^ a[16:9];
    hb = (t * 8'd29) + {a[8], a[3:0], 3'b101};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: request observation, response scheduling
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; dly <= '0; paddr <= '0; outst_err <= 0; stall_err <= 0;
      rstall_q <= 1'b0; rstall_a <= '0; req_n <= 0;
    end else begin
      if (rstall_q && (!mem_req_valid || mem_req_addr != rstall_a)) stall_err <= stall_err + 1;
      rstall_q <= mem_req_valid && !mem_req_ready;
      rstall_a <= mem_req_addr;
      if (mem_rsp_valid) pend <= 1'b0;
      else if (pend && dly != 2'd0) dly <= dly - 2'd1;
      if (mem_req_valid && mem_req_ready) begin
        if (pend) outst_err <= outst_err + 1;
        if (req_n < 256) req_a[req_n] <= mem_req_addr;
        req_n <= req_n + 1;
        pend  <= 1'b1;
        paddr <= mem_req_addr;
        dly   <= 2'(cyc % 3);
      end
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = rst_n && pend && (dly == 2'd0);
    mem_rsp_data  = hb(paddr);
    mem_req_ready = (cyc % 3) != 1;
    pix_ready     = ((cyc % 5) != 2) && ((cyc % 7) != 4);
  end

  // pixel sink
  always @(posedge clk) begin
    if (!rst_n) begin
      pix_n <= 0; done <= 1'b0; pstall_q <= 1'b0; pstall_eol <= 1'b0;
    end else begin
      if (pstall_q && (!pix_valid || pix_eol != pstall_eol)) stall_err <= stall_err + 1;
      pstall_q   <= pix_valid && !pix_ready;
      pstall_eol <= pix_eol;
      if (pix_valid && pix_ready) begin
        if (pix_n < 2048) begin
          px_d[pix_n] <= pix_data; px_l[pix_n] <= pix_eol; px_f[pix_n] <= pix_eof;
        end
        pix_n <= pix_n + 1;
        if (pix_eof) done <= 1'b1;
      end
    end
  end

  task automatic run_frame(input logic [7:0] tbv, input logic [7:0] topv,
                           input logic ratev, input bit wr_vc,
                           input logic [7:0] vc, input bit mid);
    int nl, k, p;
    logic [16:0] ea, pa;
    logic [15:0] ptr;
    logic [13:0] ofs;
    logic [7:0]  byt;
    logic        eb;
    @(negedge clk);
    if (wr_vc) begin
      vctl_wr = 1'b1; vctl_data = vc;
      cur_rev = vc[7]; cur_en = vc[6];
      @(negedge clk);
      vctl_wr = 1'b0; vctl_data = 8'h00;
    end
    req_n <= 0; pix_n <= 0; done <= 1'b0;
    @(negedge clk);
    tbl_base = tbv; top_entry = topv; rate_60 = ratev; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    tbl_base = ~tbv; top_entry = topv + 8'd77; rate_60 = ~ratev;
    if (mid) begin
      repeat (15) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    chk(done, "R7 frame end marker seen", int'(done), 1);
    repeat (6) @(negedge clk);
    nl = ratev ? L60 : L50;
    chk(req_n == nl * (2 + BYTES), "R4 request count", req_n, nl * (2 + BYTES));
    chk(pix_n == nl * BYTES * 8, "R4 pixel count", pix_n, nl * BYTES * 8);
    if (req_n != nl * (2 + BYTES) || pix_n != nl * BYTES * 8) return;
    k = 0; p = 0;
    for (int l = 0; l < nl; l++) begin
      ea = {tbv, 8'(topv + 8'(l)), 1'b0};
      chk(req_a[k] == ea, "R1 pointer low address", int'(req_a[k]), int'(ea));
      chk(req_a[k+1] == (ea | 17'd1), "R1 pointer high address", int'(req_a[k+1]), int'(ea | 17'd1));
      ptr = {hb(ea | 17'd1), hb(ea)};
      ofs = {ptr[12:3], 1'b0, ptr[2:0]};
      for (int b = 0; b < BYTES; b++) begin
        pa = {ptr[15:13], 14'(ofs + 14'(b * 8))};
        if (b == 0) chk(req_a[k+2] == pa, "R2 first pixel address", int'(req_a[k+2]), int'(pa));
        else chk(req_a[k+2+b] == pa, "R3 stride pixel address", int'(req_a[k+2+b]), int'(pa));
        byt = hb(pa);
        for (int i = 7; i >= 0; i--) begin
          eb = cur_en & (byt[i] ^ cur_rev);
          chk(px_d[p] == eb, "R8 pixel value", int'(px_d[p]), int'(eb));
          chk(px_l[p] == (i == 0 && b == BYTES - 1), "R7 line marker",
              int'(px_l[p]), int'(i == 0 && b == BYTES - 1));
          chk(px_f[p] == (i == 0 && b == BYTES - 1 && l == nl - 1), "R7 frame marker",
              int'(px_f[p]), int'(i == 0 && b == BYTES - 1 && l == nl - 1));
          p++;
        end
      end
      k += 2 + BYTES;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_valid, "R9 no request after reset", int'(mem_req_valid), 0);
    chk(!pix_valid, "R9 no pixel after reset", int'(pix_valid), 0);
    // R9: no control write yet, so the whole frame must be blank
    run_frame(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    run_frame(8'hA5, 8'h07, 1'b0, 1'b1, 8'h40, 1'b0);
    run_frame(8'h3C, 8'hFE, 1'b0, 1'b1, 8'hC0, 1'b0);
    run_frame(8'hFF, 8'hFF, 1'b1, 1'b1, 8'h40, 1'b0);
    // R10: low bits set alongside enable, must match plain enable
    run_frame(8'h12, 8'h80, 1'b0, 1'b1, 8'h7F, 1'b0);
    // R8: reverse with enable off stays blank; low bits ignored (R10)
    run_frame(8'h5A, 8'h10, 1'b1, 1'b1, 8'hBF, 1'b0);
    // R11: second start pulse and input changes mid-frame ignored
    run_frame(8'hC3, 8'hFD, 1'b0, 1'b1, 8'hC0, 1'b1);
    run_frame(8'h81, 8'h01, 1'b1, 1'b1, 8'hC0, 1'b1);
    for (int s = 0; s < 8; s++)
      run_frame(8'(s * 37 + 5), 8'(8'd252 + 8'(s)), 1'(s % 2), 1'b1,
                {1'(s / 2 % 2), 1'b1, 6'(s * 11)}, 1'b0);
    chk(outst_err == 0, "R5 single read in flight", outst_err, 0);
    chk(stall_err == 0, "R6 stalled request or pixel held", stall_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule